// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Arbiter

This block sits on the processor side of an interrupt system. It takes a set of interrupt-request lines. Each line has its own fixed priority level and its own acknowledge line, and each line may serve a group of devices chained behind it. The block holds the processor's current priority and a global interrupt-enable flag, which together form the priority part of the status word. When the processor reports that its current instruction has finished, the block picks the highest pending request whose level is strictly above the current priority. It raises the processor priority to that level and asserts the matching acknowledge line. The acknowledge stays up until the request line drops.

Software changes the priority and the enable flag through a status-word write port, which is honoured only in supervisor mode. A write attempted in user mode is dropped and produces a one-cycle privilege-exception pulse. When a service routine returns, a restore strobe reloads the priority that was in force before the interrupt. Because a higher-level line can still win while a routine runs at a raised priority, interrupts nest.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, cur_prio is 0, int_en is 0, irq_ack and ack_level are 0 and priv_exc is 0.
- R2: While int_en is 0, no acknowledge is asserted, whatever the request lines carry.
- R3: Request line i has level i+1. It can be accepted only when i+1 is strictly greater than cur_prio. Requests at or below cur_prio produce no acknowledge and stay pending.
- R4: When several eligible lines request at once, the line with the highest level wins. irq_ack is never more than one-hot.
- R5: Acceptance happens only on a clock edge where cpu_ready is 1. irq_ack rises one cycle after that edge's inputs are sampled.
- R6: In the cycle irq_ack rises, cur_prio equals the accepted level, and ack_level reports that same level.
- R7: An asserted acknowledge holds while its request line stays 1. It clears one cycle after that line is seen at 0. No new acceptance takes place while any acknowledge is held.
- R8: After an acknowledge is released, a request at a level above the raised priority is accepted, so service nests. A request at the raised level is not accepted.
- R9: A status write (sw_wr=1) with supervisor=1 loads wr_prio into cur_prio and wr_ie into int_en one cycle later.
- R10: A status write with supervisor=0 leaves cur_prio and int_en unchanged and raises priv_exc for exactly the following cycle.
- R11: restore=1 loads restore_prio into cur_prio one cycle later and takes precedence over a status write in the same cycle. No acceptance takes place in a cycle where restore or sw_wr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_LEVELS | Request lines; bit i has level i+1 |
| cpu_ready | input | 1 | Processor has finished its current instruction |
| irq_ack | output | NUM_LEVELS | One acknowledge per request line |
| ack_level | output | PW | Level currently acknowledged, 0 if none |
| sw_wr | input | 1 | Status-word write strobe |
| supervisor | input | 1 | 1 in supervisor mode, 0 in user mode |
| wr_prio | input | PW | Priority value carried by a status write |
| wr_ie | input | 1 | Enable value carried by a status write |
| priv_exc | output | 1 | One-cycle privilege-exception pulse |
| restore | input | 1 | Return-from-service strobe |
| restore_prio | input | PW | Saved priority reloaded on restore |
| cur_prio | output | PW | Current processor priority |
| int_en | output | 1 | Global interrupt enable |

## Verification
The table-driven part varies the request pattern on its own. A single low-level line with cpu_ready low and then high separates readiness gating from acceptance. Overlapping lower, equal and higher lines tell strict-greater masking apart from a greater-or-equal mistake and from a lowest-wins encoder. A drop of the held line while another stays high shows that the release is tied to its own line. Directed cases then pair writes, restores and requests in the same cycle to expose precedence errors, and fill all lines against a maximal priority to test the masking boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Source selected for the next processor priority value.
   typedef enum logic [1:0] {
      PSRC_HOLD    = 2'd0,
      PSRC_RESTORE = 2'd1,
      PSRC_WRITE   = 2'd2,
      PSRC_ACCEPT  = 2'd3
   } prio_src_e;

   // Width needed to carry levels 0..n.
   function automatic int level_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick
   import irq_arb_pkg::*;
#(
   parameter int NUM_LEVELS = 7,
   parameter int PW         = level_width(NUM_LEVELS)
) (
   input  logic [NUM_LEVELS-1:0] req,
   input  logic [PW-1:0]         cur_prio,
   input  logic                  ie,
   output logic                  win_valid,
   output logic [PW-1:0]         win_level,
   output logic [NUM_LEVELS-1:0] win_onehot
);

   logic [NUM_LEVELS-1:0] elig;

   // One comparator per line against its fixed level.
   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_elig
      localparam logic [PW-1:0] LINE_LVL = PW'(i + 1);
      assign elig[i] = req[i] & ie & (LINE_LVL > cur_prio);
   end

   // Highest eligible line wins.
   always_comb begin
      win_level = '0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (elig[i]) win_level = PW'(i + 1);
      end
   end

   assign win_valid = |elig;

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_onehot
      assign win_onehot[i] = (win_level == PW'(i + 1));
   end

endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg
   import irq_arb_pkg::*;
#(
   parameter int PW         = 3,
   parameter int RESET_PRIO = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restore,
   input  logic [PW-1:0] restore_prio,
   input  logic          sw_wr,
   input  logic          supervisor,
   input  logic [PW-1:0] wr_prio,
   input  logic          wr_ie,
   input  logic          accept,
   input  logic [PW-1:0] accept_level,
   output logic          update_busy,
   output logic [PW-1:0] cur_prio,
   output logic          int_en,
   output logic          priv_exc
);

   prio_src_e     src;
   logic [PW-1:0] prio_q;
   logic          ie_q;
   logic          exc_q;
   logic          sup_wr;

   assign sup_wr      = sw_wr & supervisor;
   assign update_busy = restore | sw_wr;

   // Restore beats a write; acceptance is only offered in quiet cycles.
   always_comb begin
      if (restore)     src = PSRC_RESTORE;
      else if (sup_wr) src = PSRC_WRITE;
      else if (accept) src = PSRC_ACCEPT;
      else             src = PSRC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= PW'(RESET_PRIO);
         ie_q   <= 1'b0;
         exc_q  <= 1'b0;
      end else begin
         case (src)
            PSRC_RESTORE: prio_q <= restore_prio;
            PSRC_WRITE: begin
               prio_q <= wr_prio;
               ie_q   <= wr_ie;
            end
            PSRC_ACCEPT:  prio_q <= accept_level;
            default:      prio_q <= prio_q;
         endcase
         exc_q <= sw_wr & ~supervisor;
      end
   end

   assign cur_prio = prio_q;
   assign int_en   = ie_q;
   assign priv_exc = exc_q;

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
   parameter int NUM_LEVELS = 7,
   parameter int PW         = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  logic [NUM_LEVELS-1:0] win_onehot,
   input  logic [NUM_LEVELS-1:0] irq_req,
   output logic [NUM_LEVELS-1:0] ack,
   output logic                  ack_busy,
   output logic [PW-1:0]         ack_level
);

   logic [NUM_LEVELS-1:0] ack_q;
   logic                  still_req;

   assign still_req = |(ack_q & irq_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ack_q <= '0;
      else if (accept)    ack_q <= win_onehot;
      else if (!still_req) ack_q <= '0;
   end

   always_comb begin
      ack_level = '0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (ack_q[i]) ack_level = PW'(i + 1);
      end
   end

   assign ack      = ack_q;
   assign ack_busy = |ack_q;

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_LEVELS = 7,
   parameter int RESET_PRIO = 0,
   parameter int PW         = level_width(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] irq_req,
   input  logic                  cpu_ready,
   output logic [NUM_LEVELS-1:0] irq_ack,
   output logic [PW-1:0]         ack_level,
   input  logic                  sw_wr,
   input  logic                  supervisor,
   input  logic [PW-1:0]         wr_prio,
   input  logic                  wr_ie,
   output logic                  priv_exc,
   input  logic                  restore,
   input  logic [PW-1:0]         restore_prio,
   output logic [PW-1:0]         cur_prio,
   output logic                  int_en
);

   // Elaboration-time parameter checks.
   if (NUM_LEVELS < 1 || NUM_LEVELS > 64) begin : g_bad_levels
      $error("irq_level_arbiter: NUM_LEVELS must lie in 1..64");
   end
   if (RESET_PRIO < 0 || RESET_PRIO > NUM_LEVELS) begin : g_bad_reset
      $error("irq_level_arbiter: RESET_PRIO out of range");
   end
   if (PW < level_width(NUM_LEVELS)) begin : g_bad_pw
      $error("irq_level_arbiter: PW too narrow for NUM_LEVELS");
   end

   logic                  win_valid;
   logic [PW-1:0]         win_level;
   logic [NUM_LEVELS-1:0] win_onehot;
   logic                  ack_busy;
   logic                  update_busy;
   logic                  accept;

   irq_lvl_pick #(.NUM_LEVELS(NUM_LEVELS), .PW(PW)) u_pick (
      .req        (irq_req),
      .cur_prio   (cur_prio),
      .ie         (int_en),
      .win_valid  (win_valid),
      .win_level  (win_level),
      .win_onehot (win_onehot)
   );

   assign accept = win_valid & cpu_ready & ~ack_busy & ~update_busy;

   irq_prio_reg #(.PW(PW), .RESET_PRIO(RESET_PRIO)) u_prio (
      .clk          (clk),
      .rst_n        (rst_n),
      .restore      (restore),
      .restore_prio (restore_prio),
      .sw_wr        (sw_wr),
      .supervisor   (supervisor),
      .wr_prio      (wr_prio),
      .wr_ie        (wr_ie),
      .accept       (accept),
      .accept_level (win_level),
      .update_busy  (update_busy),
      .cur_prio     (cur_prio),
      .int_en       (int_en),
      .priv_exc     (priv_exc)
   );

   irq_ack_ctrl #(.NUM_LEVELS(NUM_LEVELS), .PW(PW)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .win_onehot (win_onehot),
      .irq_req    (irq_req),
      .ack        (irq_ack),
      .ack_busy   (ack_busy),
      .ack_level  (ack_level)
   );

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
   parameter int NUM_LEVELS = 7,
   parameter int PW         = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_LEVELS-1:0] irq_req,
   input logic                  cpu_ready,
   input logic [NUM_LEVELS-1:0] irq_ack,
   input logic [PW-1:0]         ack_level,
   input logic                  sw_wr,
   input logic                  supervisor,
   input logic [PW-1:0]         wr_prio,
   input logic                  wr_ie,
   input logic                  priv_exc,
   input logic                  restore,
   input logic [PW-1:0]         restore_prio,
   input logic [PW-1:0]         cur_prio,
   input logic                  int_en
);

   p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack == '0 && !int_en) |=> (irq_ack == '0));

   p_above_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_level == '0) |=> (ack_level == '0 || ack_level > $past(cur_prio)));

   p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_level == '0 && !cpu_ready) |=> (ack_level == '0));

   p_prio_raised_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_level == '0) |=> (ack_level == '0 || cur_prio == ack_level));

   p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_ack & irq_req)) |=> $stable(irq_ack));

   p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0 && !(|(irq_ack & irq_req))) |=> (irq_ack == '0));

   p_sup_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && supervisor && !restore) |=>
         (cur_prio == $past(wr_prio) && int_en == $past(wr_ie)));

   p_user_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !supervisor && !restore) |=>
         (priv_exc && $stable(cur_prio) && $stable(int_en)));

   p_exc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr || supervisor) |=> !priv_exc);

   p_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> (cur_prio == $past(restore_prio)));

   p_no_accept_on_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((restore || sw_wr) && irq_ack == '0) |=> (irq_ack == '0));

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NUM_LEVELS(NUM_LEVELS), .PW(PW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_req      (irq_req),
   .cpu_ready    (cpu_ready),
   .irq_ack      (irq_ack),
   .ack_level    (ack_level),
   .sw_wr        (sw_wr),
   .supervisor   (supervisor),
   .wr_prio      (wr_prio),
   .wr_ie        (wr_ie),
   .priv_exc     (priv_exc),
   .restore      (restore),
   .restore_prio (restore_prio),
   .cur_prio     (cur_prio),
   .int_en       (int_en)
);

// File: tb/irq_level_arbiter_test.sv
module irq_level_arbiter_test;

   localparam int N  = 7;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic          cpu_ready = 1'b0;
   logic [N-1:0]  irq_ack;
   logic [PW-1:0] ack_level;
   logic          sw_wr = 1'b0;
   logic          supervisor = 1'b0;
   logic [PW-1:0] wr_prio = '0;
   logic          wr_ie = 1'b0;
   logic          priv_exc;
   logic          restore = 1'b0;
   logic [PW-1:0] restore_prio = '0;
   logic [PW-1:0] cur_prio;
   logic          int_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_level_arbiter #(.NUM_LEVELS(N)) uut (
      .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .cpu_ready (cpu_ready),
      .irq_ack (irq_ack), .ack_level (ack_level), .sw_wr (sw_wr),
      .supervisor (supervisor), .wr_prio (wr_prio), .wr_ie (wr_ie),
      .priv_exc (priv_exc), .restore (restore), .restore_prio (restore_prio),
      .cur_prio (cur_prio), .int_en (int_en)
   );

   typedef struct packed {
      logic [N-1:0]  req;
      logic          rdy;
      logic [N-1:0]  ack;
      logic [PW-1:0] prio;
   } vec_t;

   // Walked from cur_prio=0, int_en=1, no acknowledge.
   localparam vec_t TBL [9] = '{
      '{7'b0000100, 1'b0, 7'b0000000, 3'd0},  // R5 not ready
      '{7'b0000100, 1'b1, 7'b0000100, 3'd3},  // R5 R6 accept level 3
      '{7'b0000100, 1'b1, 7'b0000100, 3'd3},  // R7 hold
      '{7'b0000110, 1'b1, 7'b0000100, 3'd3},  // R7 no accept while held
      '{7'b0000010, 1'b1, 7'b0000000, 3'd3},  // R7 release on drop
      '{7'b0000010, 1'b1, 7'b0000000, 3'd3},  // R3 lower pending
      '{7'b0000110, 1'b1, 7'b0000000, 3'd3},  // R3 R8 equal not accepted
      '{7'b1010110, 1'b1, 7'b1000000, 3'd7},  // R4 R8 highest nests
      '{7'b0000000, 1'b1, 7'b0000000, 3'd7}   // R7 release
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #12;
      // R1 reset state
      check("R1 cur_prio", int'(cur_prio), 0);
      check("R1 int_en", int'(int_en), 0);
      check("R1 irq_ack", int'(irq_ack), 0);
      check("R1 priv_exc", int'(priv_exc), 0);
      rst_n = 1'b1;
      tick();

      // R2 disabled: nothing accepted
      irq_req = '1; cpu_ready = 1'b1;
      tick(); tick(); tick();
      check("R2 ack while disabled", int'(irq_ack), 0);
      irq_req = '0;
      tick();

      // R10 user-mode write dropped
      sw_wr = 1'b1; supervisor = 1'b0; wr_prio = 3'd5; wr_ie = 1'b1;
      tick();
      sw_wr = 1'b0;
      check("R10 priv_exc pulse", int'(priv_exc), 1);
      check("R10 prio kept", int'(cur_prio), 0);
      check("R10 ie kept", int'(int_en), 0);
      tick();
      check("R10 pulse one cycle", int'(priv_exc), 0);

      // R9 supervisor write
      sw_wr = 1'b1; supervisor = 1'b1; wr_prio = 3'd0; wr_ie = 1'b1;
      tick();
      sw_wr = 1'b0;
      check("R9 ie set", int'(int_en), 1);
      check("R9 prio", int'(cur_prio), 0);
      check("R9 no exc", int'(priv_exc), 0);

      // Vector walk
      for (int k = 0; k < 9; k++) begin
         irq_req = TBL[k].req; cpu_ready = TBL[k].rdy;
         tick();
         check($sformatf("R3-walk%0d ack (R4 R5 R6 R7 R8)", k), int'(irq_ack), int'(TBL[k].ack));
         check($sformatf("walk%0d prio (R6)", k), int'(cur_prio), int'(TBL[k].prio));
      end

      // R11 restore beats write
      restore = 1'b1; restore_prio = 3'd2;
      sw_wr = 1'b1; supervisor = 1'b1; wr_prio = 3'd6; wr_ie = 1'b1;
      tick();
      restore = 1'b0; sw_wr = 1'b0;
      check("R11 restore precedence", int'(cur_prio), 2);

      // R11 acceptance suppressed during a write
      irq_req = 7'b0001000; cpu_ready = 1'b1;
      sw_wr = 1'b1; wr_prio = 3'd1; wr_ie = 1'b1;
      tick();
      sw_wr = 1'b0;
      check("R11 no accept on write", int'(irq_ack), 0);
      check("R11 write applied", int'(cur_prio), 1);
      tick();
      check("R6 ack level 4", int'(irq_ack), 8);
      check("R6 prio 4", int'(cur_prio), 4);
      check("R6 ack_level", int'(ack_level), 4);
      irq_req = '0;
      tick();
      check("R7 released", int'(irq_ack), 0);

      // R3 boundary: priority at top level masks all
      sw_wr = 1'b1; wr_prio = 3'd7; irq_req = '1;
      tick();
      sw_wr = 1'b0;
      tick(); tick();
      check("R3 top prio masks all", int'(irq_ack), 0);
      check("R9 prio 7", int'(cur_prio), 7);

      // R10 again while supervisor write absent
      irq_req = '0;
      supervisor = 1'b0; sw_wr = 1'b1; wr_prio = 3'd0;
      tick();
      sw_wr = 1'b0;
      check("R10 user write kept prio", int'(cur_prio), 7);
      check("R10 exc", int'(priv_exc), 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule